// File: doc/BRIEF.md
# Segmented Bus-Invert Codec

This block reduces the number of wires that switch on a wide parallel bus. On the transmit side, each incoming word is compared, segment by segment, with the value the bus currently holds. For every segment the encoder sends either the true bits or their complement, whichever makes fewer lines change. A per-segment flag line tells the far end which choice was made. When the flag line itself would change, that change is counted as a toggle too.

A parameter sets how many equal segments the bus is cut into. With a single segment the block is a plain whole-bus inverter suited to data traffic. With several segments each part decides on its own, which suits address-like traffic where only some fields move. The receive side XORs each segment with its flag to recover the word, and it raises a valid strobe aligned with the recovered data.

Top module: `bus_invert_codec`

## Requirements
- R1: After reset, the encoded bus, all flags, the decoded data and the output valid strobe are zero.
- R2: In any cycle where `valid_i` is low, the encoded bus and all flags keep their values.
- R3: A flag value of 1 means the segment carries the complement of the input bits, and 0 means it carries the true bits. On a valid cycle each segment picks the choice with the lower toggle count on its data lines plus its flag line, counted against the value it held in the previous cycle.
- R4: When both choices give the same toggle count, which can only happen when the segment width is odd, the segment keeps its previous flag value.
- R5: On any clock edge, the data lines plus the flag line of one segment change in at most floor((SEG_W+1)/2) places.
- R6: Segment k covers bits [k*SEG_W +: SEG_W] and is driven by flag bit k. Each segment decides using only its own bits and its own flag.
- R7: `data_o` holds the decode of the bus value from one cycle earlier. `valid_o` rises two cycles after `valid_i`, and `data_o` then equals the word that was presented.
- R8: With `NUM_SEG` = 1, a single flag governs the entire bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input word qualifier |
| data_i | input | DATA_W | Raw word to transmit |
| bus_o | output | DATA_W | Encoded bus lines |
| flag_o | output | NUM_SEG | Per-segment invert flags |
| data_o | output | DATA_W | Recovered word |
| valid_o | output | 1 | Recovered word qualifier |

## Verification
The bench builds two copies that share the same stimulus. One copy is 16 bits wide in four 4-bit segments. Its even segment width makes the two choices always differ in cost, so every decision is strict, and segments are driven into different decisions in the same cycle. The other copy is 9 bits wide in a single segment. This gives whole-bus inversion, and because the width is odd it makes exact cost ties reachable, so keeping the flag on a tie can be shown with both flag values.

// File: rtl/biv_pkg.sv
`timescale 1ns/1ps
package biv_pkg;
  localparam int unsigned MAX_SEG_W = 64;

  function automatic logic [7:0] popcnt(input logic [MAX_SEG_W-1:0] v);
    logic [7:0] c;
    c = '0;
    for (int i = 0; i < MAX_SEG_W; i++) c = c + 8'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/biv_seg_enc.sv
`timescale 1ns/1ps
module biv_seg_enc
  import biv_pkg::*;
#(
  parameter int unsigned SEG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SEG_W-1:0] data_i,
  output logic [SEG_W-1:0] bus_o,
  output logic             flag_o
);
  localparam int unsigned BOUND = (SEG_W + 1) / 2;

  logic [SEG_W-1:0] bus_q;
  logic             flag_q;
  logic [7:0]       ham, cost_pl, cost_iv;
  logic             inv_sel;

  always_comb begin
    ham     = popcnt(MAX_SEG_W'(data_i ^ bus_q));
    cost_pl = ham + 8'(flag_q);
    cost_iv = 8'(SEG_W) - ham + 8'(!flag_q);
    if (cost_iv < cost_pl)      inv_sel = 1'b1;
    else if (cost_pl < cost_iv) inv_sel = 1'b0;
    else                        inv_sel = flag_q; // tie keeps flag
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= '0;
      flag_q <= 1'b0;
    end else if (valid_i) begin
      flag_q <= inv_sel;
      bus_q  <= inv_sel ? ~data_i : data_i;
    end
  end

  assign bus_o  = bus_q;
  assign flag_o = flag_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(bus_q) && $stable(flag_q));

  p_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones({bus_q, flag_q} ^ $past({bus_q, flag_q})) <= BOUND);

  p_same_word_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !flag_q && data_i == bus_q) |=> $stable(bus_q) && !flag_q);
endmodule

// File: rtl/biv_dec.sv
`timescale 1ns/1ps
module biv_dec #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  bus_i,
  input  logic [NUM_SEG-1:0] flag_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam int unsigned SEG_W = DATA_W / NUM_SEG;

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] data_q;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_mask
    assign mask[s*SEG_W +: SEG_W] = {SEG_W{flag_i[s]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= bus_i ^ mask;
  end

  assign data_o = data_q;
endmodule

// File: rtl/bus_invert_codec.sv
`timescale 1ns/1ps
module bus_invert_codec #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SEG = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  bus_o,
  output logic [NUM_SEG-1:0] flag_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               valid_o
);
  localparam int unsigned SEG_W = DATA_W / NUM_SEG;

  logic [1:0] vld_q;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    biv_seg_enc #(.SEG_W(SEG_W)) u_enc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(valid_i),
      .data_i (data_i[s*SEG_W +: SEG_W]),
      .bus_o  (bus_o[s*SEG_W +: SEG_W]),
      .flag_o (flag_o[s])
    );
  end

  biv_dec #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bus_i (bus_o),
    .flag_i(flag_o),
    .data_o(data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[0], valid_i};
  end

  assign valid_o = vld_q[1];

  p_roundtrip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> data_o == $past(data_i, 2));
endmodule

// File: tb/sim_bus_invert_codec.sv
`timescale 1ns/1ps
module sim_bus_invert_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] data_i = '0;

  logic [15:0] bus0, dout0;
  logic [3:0]  flag0;
  logic        vout0;
  logic [8:0]  bus1, dout1;
  logic [0:0]  flag1;
  logic        vout1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [15:0] mb0 = '0, mb1 = '0;
  logic [3:0]  mf0 = '0, mf1 = '0;
  logic [15:0] lw0 = '0, lw1 = '0;
  logic        pv = 1'b0;
  logic [15:0] pa0 = '0;
  logic [3:0]  pf0 = '0;
  logic [8:0]  pa1 = '0;
  logic        pf1 = 1'b0;

  always #2.5 clk = ~clk;

  bus_invert_codec #(.DATA_W(16), .NUM_SEG(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .bus_o(bus0), .flag_o(flag0), .data_o(dout0), .valid_o(vout0));

  bus_invert_codec #(.DATA_W(9), .NUM_SEG(1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i[8:0]),
    .bus_o(bus1), .flag_o(flag1), .data_o(dout1), .valid_o(vout1));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] d, input int dw, input int sw,
                       inout logic [15:0] b, inout logic [3:0] f);
    logic [15:0] nb;
    nb = b;
    for (int s = 0; s < dw / sw; s++) begin
      int ham, cp, ci;
      logic inv;
      ham = 0;
      for (int i = 0; i < sw; i++) ham += int'(d[s*sw+i] ^ b[s*sw+i]);
      cp = ham + int'(f[s]);
      ci = sw - ham + (f[s] ? 0 : 1);
      if (ci < cp)      inv = 1'b1;
      else if (cp < ci) inv = 1'b0;
      else              inv = f[s];
      f[s] = inv;
      for (int i = 0; i < sw; i++) nb[s*sw+i] = inv ? ~d[s*sw+i] : d[s*sw+i];
    end
    b = nb;
  endtask

  task automatic step(input logic [15:0] d, input logic v, input string tag);
    int t;
    @(negedge clk);
    valid_i = v;
    data_i  = d;
    @(posedge clk);
    #1;
    if (v) begin
      model(d, 16, 4, mb0, mf0);
      model({7'd0, d[8:0]}, 9, 9, mb1, mf1);
    end
    chk(bus0 == mb0, tag, "u0 bus", 32'(bus0), 32'(mb0));
    chk(flag0 == mf0, tag, "u0 flags", 32'(flag0), 32'(mf0));
    chk(bus1 == mb1[8:0], tag, "u1 bus", 32'(bus1), 32'(mb1[8:0]));
    chk(flag1[0] == mf1[0], tag, "u1 flag", 32'(flag1), 32'(mf1[0]));
    for (int s = 0; s < 4; s++) begin
      t = $countones((bus0[s*4 +: 4] ^ pa0[s*4 +: 4])) + int'(flag0[s] ^ pf0[s]);
      chk(t <= 2, "R5", "u0 seg toggles", 32'(t), 32'd2);
    end
    t = $countones(bus1 ^ pa1) + int'(flag1[0] ^ pf1);
    chk(t <= 5, "R5", "u1 toggles", 32'(t), 32'd5);
    chk(dout0 == lw0, "R7", "u0 data_o", 32'(dout0), 32'(lw0));
    chk(dout1 == lw1[8:0], "R7", "u1 data_o", 32'(dout1), 32'(lw1[8:0]));
    chk(vout0 == pv && vout1 == pv, "R7", "valid_o", 32'({vout0, vout1}), 32'({pv, pv}));
    pa0 = bus0; pf0 = flag0; pa1 = bus1; pf1 = flag1[0];
    pv = v;
    if (v) begin
      lw0 = d;
      lw1 = {7'd0, d[8:0]};
    end
  endtask

  task automatic t_reset;
    #1;
    chk(bus0 == 0 && flag0 == 0 && dout0 == 0 && vout0 == 0, "R1", "u0 reset",
        32'({bus0, flag0}), 32'd0);
    chk(bus1 == 0 && flag1 == 0 && dout1 == 0 && vout1 == 0, "R1", "u1 reset",
        32'({bus1, flag1}), 32'd0);
  endtask

  task automatic t_tie;
    step(16'h001F, 1'b1, "R4");
    chk(flag1 == 1'b0 && bus1 == 9'h01F, "R4", "u1 tie flag0",
        32'({bus1, flag1}), 32'({9'h01F, 1'b0}));
    step(16'h01E0, 1'b1, "R8");
    chk(flag1 == 1'b1 && bus1 == 9'h01F, "R8", "u1 whole-bus invert",
        32'({bus1, flag1}), 32'({9'h01F, 1'b1}));
    step(16'h0010, 1'b1, "R4");
    chk(flag1 == 1'b1 && bus1 == 9'h1EF, "R4", "u1 tie flag1",
        32'({bus1, flag1}), 32'({9'h1EF, 1'b1}));
  endtask

  task automatic t_segments;
    step(16'h0000, 1'b1, "R3");
    step(16'hFFFF, 1'b1, "R3");
    step(16'h0F0F, 1'b1, "R6");
    step(16'h00F0, 1'b1, "R6");
    step(16'h1234, 1'b1, "R3");
    step(16'hEDCB, 1'b1, "R6");
  endtask

  task automatic t_hold;
    logic [15:0] hb;
    logic [3:0]  hf;
    hb = bus0; hf = flag0;
    step(16'hA5A5, 1'b0, "R2");
    step(16'h5A5A, 1'b0, "R2");
    chk(bus0 == hb && flag0 == hf, "R2", "u0 hold", 32'({bus0, flag0}), 32'({hb, hf}));
    step(16'hA5A5, 1'b1, "R2");
  endtask

  task automatic t_adversarial;
    for (int k = 0; k < 20; k++) step((k % 2) ? 16'hFFFF : 16'h0000, 1'b1, "R5");
    for (int k = 0; k < 20; k++) step((k % 2) ? 16'hAAAA : 16'h5555, 1'b1, "R5");
    for (int k = 0; k < 16; k++) step(16'h1 << k, 1'b1, "R6");
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) step(16'($urandom), ($urandom % 4) != 0, "R7");
  endtask

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_tie();
    t_segments();
    t_hold();
    t_adversarial();
    t_random();
    step(16'h0, 1'b0, "R7");
    step(16'h0, 1'b0, "R7");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule